// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block produces one general-purpose output clock from a bank of up to eleven source clocks. A 4-bit code picks the source, which is divided by an 8-bit integer. Divisors 0 and 1 pass the chosen source straight through. For odd divisors, the high and low times can be equalised by also using the falling edge of the source. Software reaches the block through a small register port in the system clock domain. There are two registers: a control word and a divisor.

The enable bit is carried into the source domain by a two-flop synchroniser. The output starts at the beginning of a divided period and stops at its end, so no short pulse can appear. A programmable delay of 0 to 3 source cycles can be placed on the enable. Each edge of the nudge bit pushes the output phase one source cycle later. A kill bit forces the output low at once and clears the source-domain state asynchronously. Software must change the source code only while the generator is disabled.

Top module: `clkout_gen`

## Requirements
- R1: After reset, both registers read 0 and `clk_out` is low.
- R2: Address 0 is the control word and address 1 is the divisor. The control fields are: source code in bits 8:5, kill in bit 10, enable in bit 11, duty correction in bit 12, start delay in bits 17:16 and nudge in bit 20. All other control bits read 0, so writing all ones reads back 0x00131DE0. The divisor reads back in bits 7:0, and bits 31:8 read 0.
- R3: With divisor N ≥ 2 and duty correction off, the output period is N·T and the high time is floor(N/2)·T, where T is the source period.
- R4: With divisor 0 or 1, the output follows the selected source: period T and high time T/2.
- R5: With duty correction on and N odd, the high time is N·T/2 and the period stays N·T. For even N the high time is unchanged.
- R6: Source codes 0 to 10 select `src_clk[code]`. Codes 11 to 15 select no clock, and `clk_out` stays low even while the generator is enabled.
- R7: While kill is set, `clk_out` is low without waiting for any source edge, and it produces no rising edge.
- R8: Clearing enable stops the output only at the end of a period. No high pulse is shorter than the normal high time, and afterwards the output stays low.
- R9: A start delay of p, written while disabled, makes the first output rising edge come exactly p·T later than with delay 0. Writing a new delay while the generator runs leaves the period unchanged.
- R10: Each edge of the nudge bit, 0→1 or 1→0, shifts all later output edges one source period later, and the shifts add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Register port clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 divisor |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 divisor |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| src_clk | input | NUM_SRC | Source clocks |
| clk_out | output | 1 | Divided output clock |

## Verification
The divider is run with random pairs of source and divisor, with duty correction on and off. Matching both period and high time tells apart odd and even divisors, the pass-through case and the half-cycle correction. It also shows whether the selected input is the right source, since each source has a distinct period. Directed cases fill in the rest:
- The delay latencies are measured against a fixed alignment between register write and source edge, so a one-cycle error in the delay tap shows up.
- The nudge shift is measured as a phase offset modulo the period, which separates a single slip from none or two.
- The stop is checked for runt pulses.
- The kill and invalid-code checks count edges over an idle window.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
    localparam int REG_W     = 32;
    localparam int SEL_LSB   = 5;
    localparam int SEL_W     = 4;
    localparam int KILL_BIT  = 10;
    localparam int EN_BIT    = 11;
    localparam int DC_BIT    = 12;
    localparam int PH_LSB    = 16;
    localparam int PH_W      = 2;
    localparam int NUDGE_BIT = 20;

    function automatic logic [REG_W-1:0] ctrl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < SEL_W; i++) m[SEL_LSB+i] = 1'b1;
        for (int i = 0; i < PH_W; i++)  m[PH_LSB+i]  = 1'b1;
        m[KILL_BIT]  = 1'b1;
        m[EN_BIT]    = 1'b1;
        m[DC_BIT]    = 1'b1;
        m[NUDGE_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask();

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             kill;
        logic             en;
        logic             dc50;
        logic [PH_W-1:0]  phase;
        logic             nudge;
    } ctrl_t;
endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkout_regs.sv
module clkout_regs
    import clkout_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             sys_clk,
    input  logic             sys_rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output ctrl_t            ctrl,
    output logic [DIV_W-1:0] div
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wr_bits;

    assign unused_wr_bits = ^(wr_data & ~CTRL_MASK);

    always_comb begin
        r_d = r_q;
        if (wr_en && !wr_addr) begin
            r_d.ctrl.sel   = wr_data[SEL_LSB +: SEL_W];
            r_d.ctrl.kill  = wr_data[KILL_BIT];
            r_d.ctrl.en    = wr_data[EN_BIT];
            r_d.ctrl.dc50  = wr_data[DC_BIT];
            r_d.ctrl.phase = wr_data[PH_LSB +: PH_W];
            r_d.ctrl.nudge = wr_data[NUDGE_BIT];
        end
        if (wr_en && wr_addr) r_d.div = wr_data[DIV_W-1:0];
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) r_q <= '0;
        else            r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr) begin
            rd_data[DIV_W-1:0] = r_q.div;
        end else begin
            rd_data[SEL_LSB +: SEL_W] = r_q.ctrl.sel;
            rd_data[KILL_BIT]         = r_q.ctrl.kill;
            rd_data[EN_BIT]           = r_q.ctrl.en;
            rd_data[DC_BIT]           = r_q.ctrl.dc50;
            rd_data[PH_LSB +: PH_W]   = r_q.ctrl.phase;
            rd_data[NUDGE_BIT]        = r_q.ctrl.nudge;
        end
    end

    assign ctrl = r_q.ctrl;
    assign div  = r_q.div;

    // R2: unmapped bits never read back as one
    p_reserved_zero_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        rd_addr ? (rd_data[REG_W-1:DIV_W] == '0) : ((rd_data & ~CTRL_MASK) == '0));
endmodule

// File: rtl/clkout_core.sv
module clkout_core
    import clkout_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             nud_s,
    input  logic [PH_W-1:0]  phase_in,
    input  logic [DIV_W-1:0] div_in,
    input  logic             dc50_in,
    output logic             clk_o
);
    localparam int PH_DEPTH = (1 << PH_W) - 1;

    typedef struct packed {
        logic [PH_DEPTH-1:0] sh;
        logic [PH_W-1:0]     ph;
        logic                nud;
        logic                run;
        logic [DIV_W-1:0]    cnt;
        logic                pos;
    } st_t;

    st_t              st_d, st_q;
    logic [PH_DEPTH:0] tap;
    logic              en_ph, nud_edge, last, div1, odd;
    logic [DIV_W-1:0]  ndiv, hi;
    logic              neg_q, gate_q;

    always_comb begin
        div1     = (div_in < DIV_W'(2));
        ndiv     = div1 ? DIV_W'(2) : div_in;
        hi       = ndiv >> 1;
        odd      = ndiv[0];
        last     = (st_q.cnt >= ndiv - DIV_W'(1));
        tap      = {st_q.sh, en_s};
        en_ph    = tap[st_q.ph];
        nud_edge = nud_s ^ st_q.nud;

        st_d     = st_q;
        st_d.sh  = {st_q.sh[PH_DEPTH-2:0], en_s};
        st_d.nud = nud_s;
        if (!en_s) st_d.ph = phase_in;

        if (!st_q.run) begin
            st_d.cnt = '0;
            if (en_ph) st_d.run = 1'b1;
        end else if (nud_edge) begin
            st_d.cnt = st_q.cnt;
        end else if (last) begin
            st_d.cnt = '0;
            if (!en_ph) st_d.run = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        st_d.pos = st_d.run && (st_d.cnt < hi);
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            neg_q  <= st_q.pos;
            gate_q <= en_ph && div1;
        end
    end

    always_comb begin
        if (div1)                clk_o = sclk && gate_q;
        else if (dc50_in && odd) clk_o = st_q.pos || neg_q;
        else                     clk_o = st_q.pos;
    end

    // R3: counter returns to zero after the last count of a period
    p_wrap_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (st_q.run && !nud_edge && last) |=> (st_q.cnt == '0));
    // R10: a nudge edge freezes the counter for one cycle
    p_nudge_hold_r10: assert property (@(posedge sclk) disable iff (!rst_n)
        (st_q.run && nud_edge) |=> $stable(st_q.cnt));
    // R9: running only begins once the delayed enable is seen
    p_start_gated_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(st_q.run) |-> $past(en_ph));
    // R8: running only ends on a period boundary
    p_stop_boundary_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(last));
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int NUM_SRC = 11,
    parameter int DIV_W   = 8
) (
    input  logic               sys_clk,
    input  logic               sys_rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic               clk_out
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div;
    logic             sclk, src_rst_n, core_clk;
    logic [1:0]       sync_q;

    clkout_regs #(.DIV_W(DIV_W)) u_regs (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ctrl      (ctrl),
        .div       (div)
    );

    always_comb begin
        sclk = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ctrl.sel == SEL_W'(i)) sclk = src_clk[i];
        end
    end

    assign src_rst_n = sys_rst_n && !ctrl.kill;

    clkout_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (sclk),
        .rst_n (src_rst_n),
        .d     ({ctrl.nudge, ctrl.en}),
        .q     (sync_q)
    );

    clkout_core #(.DIV_W(DIV_W)) u_core (
        .sclk     (sclk),
        .rst_n    (src_rst_n),
        .en_s     (sync_q[0]),
        .nud_s    (sync_q[1]),
        .phase_in (ctrl.phase),
        .div_in   (div),
        .dc50_in  (ctrl.dc50),
        .clk_o    (core_clk)
    );

    assign clk_out = core_clk && !ctrl.kill;

    // R7: kill holds the output low, sampled in the register domain
    p_kill_low_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ctrl.kill |-> !clk_out);
endmodule

// File: tb/tb_clkout_gen.sv
`timescale 1ns/1ps
module tb_clkout_gen;
    localparam int NSRC = 11;

    logic        sys_clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NSRC-1:0] src_clk;
    logic        clk_out;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    realtime t_last_rise = 0, t_prev_rise = 0, hw = 0, min_hw = 1e9, t_w = 0;
    int n_rise = 0;

    always #4 sys_clk = ~sys_clk;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic c = 1'b0;
        always #(8 + 4*i) c = ~c;
        assign src_clk[i] = c;
    end

    clkout_gen dut (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_clk(src_clk), .clk_out(clk_out)
    );

    always @(posedge clk_out) begin
        t_prev_rise = t_last_rise;
        t_last_rise = $realtime;
        n_rise++;
    end
    always @(negedge clk_out) begin
        hw = $realtime - t_last_rise;
        if (hw < min_hw) min_hw = hw;
    end

    function automatic longint ps(realtime t);
        return longint'($rtoi(t * 1000.0 + 0.5));
    endfunction
    function automatic int tsrc(int sel);
        return 16 + 8*sel;
    endfunction
    function automatic longint exp_per(int n, int sel);
        return longint'((n < 2 ? 1 : n) * tsrc(sel)) * 1000;
    endfunction
    function automatic longint exp_high(int n, int sel, bit dc);
        if (n < 2)             return longint'(tsrc(sel)) * 500;
        if (dc && (n % 2 == 1)) return longint'(n * tsrc(sel)) * 500;
        return longint'((n / 2) * tsrc(sel)) * 1000;
    endfunction
    function automatic logic [31:0] cw(int sel, bit en, bit dc, int ph, bit nud, bit kill);
        return (32'(sel) << 5) | (32'(kill) << 10) | (32'(en) << 11) |
               (32'(dc) << 12) | (32'(ph) << 16) | (32'(nud) << 20);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(bit a, logic [31:0] d);
        @(negedge sys_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge sys_clk);
        t_w = $realtime;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(bit a, output logic [31:0] d);
        @(negedge sys_clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic measure(output longint per, output longint high);
        @(posedge clk_out); @(posedge clk_out); @(posedge clk_out);
        @(negedge clk_out);
        per  = ps(t_last_rise - t_prev_rise);
        high = ps(hw);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        longint per, high, d0, lat0, lat;
        int cur_sel, nr;
        #20;
        chk("R1 clk_out in reset", longint'(clk_out), 0);
        sys_rst_n = 1'b1;
        rd(0, v); chk("R1 ctrl reset", longint'(v), 0);
        rd(1, v); chk("R1 div reset", longint'(v), 0);
        chk("R1 clk_out after reset", longint'(clk_out), 0);

        // R2 reserved bits
        wr(1, 32'hFFFF_FFFF);
        rd(1, v); chk("R2 div readback", longint'(v), 32'h0000_00FF);
        wr(0, 32'hFFFF_FFFF & ~cw(0, 1, 0, 0, 0, 0));
        rd(0, v); chk("R2 ctrl readback", longint'(v | cw(0, 1, 0, 0, 0, 0)), 32'h0013_1DE0);
        wr(0, 32'h0000_0000);
        #1000;

        // R3 R4 R5 R6 random divider/source/duty mix
        void'($urandom(32'h5EED_1234));
        cur_sel = 0;
        for (int it = 0; it < 14; it++) begin
            int sel, n;
            bit dc;
            sel = int'($urandom % 11);
            n   = int'($urandom % 12);
            dc  = 1'($urandom % 2);
            if (it == 0) begin sel = 3; n = 1; dc = 0; end
            if (it == 1) begin sel = 0; n = 0; dc = 1; end
            if (it == 2) begin sel = 10; n = 7; dc = 1; end
            if (it == 3) begin sel = 2; n = 6; dc = 1; end
            wr(0, cw(cur_sel, 0, 0, 0, 0, 0));
            #3000;
            wr(1, 32'(n));
            wr(0, cw(sel, 0, dc, 0, 0, 0));
            #200;
            wr(0, cw(sel, 1, dc, 0, 0, 0));
            cur_sel = sel;
            measure(per, high);
            chk($sformatf("R3/R4/R6 period sel=%0d n=%0d", sel, n), per, exp_per(n, sel));
            chk($sformatf("R3/R4/R5 high sel=%0d n=%0d dc=%0d", sel, n, dc), high, exp_high(n, sel, dc));
        end

        // R6 invalid code
        wr(0, cw(cur_sel, 0, 0, 0, 0, 0));
        #3000;
        wr(1, 32'd4);
        wr(0, cw(12, 0, 0, 0, 0, 0));
        wr(0, cw(12, 1, 0, 0, 0, 0));
        #500;
        nr = n_rise;
        #2000;
        chk("R6 invalid code no edges", longint'(n_rise - nr), 0);
        chk("R6 invalid code level", longint'(clk_out), 0);
        wr(0, cw(12, 0, 0, 0, 0, 0));
        #200;

        // R9 start delay latency, source 1 (T=24), divisor 4
        lat0 = 0;
        for (int p = 0; p < 4; p++) begin
            wr(0, cw(1, 0, 0, 0, 0, 0));
            #3000;
            wr(0, cw(1, 0, 0, p, 0, 0));
            #200;
            @(posedge src_clk[1]);
            wr(0, cw(1, 1, 0, p, 0, 0));
            @(posedge clk_out);
            lat = ps($realtime - t_w);
            if (p == 0) lat0 = lat;
            else chk($sformatf("R9 delay %0d latency", p), lat - lat0, longint'(p * 24) * 1000);
        end
        wr(0, cw(1, 1, 0, 0, 0, 0));
        measure(per, high);
        chk("R9 delay change while running", per, 96000);

        // R10 nudge on source 0 (T=16), divisor 5
        wr(0, cw(1, 0, 0, 0, 0, 0));
        #3000;
        wr(1, 32'd5);
        wr(0, cw(0, 0, 0, 0, 0, 0));
        wr(0, cw(0, 1, 0, 0, 0, 0));
        measure(per, high);
        d0 = ps(t_last_rise);
        wr(0, cw(0, 1, 0, 0, 1, 0));
        #2000;
        @(posedge clk_out);
        chk("R10 rising nudge shift", (ps(t_last_rise) - d0) % 80000, 16000);
        wr(0, cw(0, 1, 0, 0, 0, 0));
        #2000;
        @(posedge clk_out);
        chk("R10 falling nudge shift", (ps(t_last_rise) - d0) % 80000, 32000);

        // R8 clean stop, source 2 (T=32), divisor 6
        wr(0, cw(0, 0, 0, 0, 0, 0));
        #3000;
        wr(1, 32'd6);
        wr(0, cw(2, 0, 0, 0, 0, 0));
        wr(0, cw(2, 1, 0, 0, 0, 0));
        measure(per, high);
        min_hw = 1e9;
        @(posedge clk_out);
        #40;
        wr(0, cw(2, 0, 0, 0, 0, 0));
        #2000;
        chk("R8 no runt pulse", longint'(ps(min_hw) >= 96000), 1);
        nr = n_rise;
        #1500;
        chk("R8 stays low after stop", longint'(n_rise - nr) + longint'(clk_out), 0);

        // R7 kill, source 0, divisor 2
        wr(1, 32'd2);
        wr(0, cw(0, 0, 0, 0, 0, 0));
        wr(0, cw(0, 1, 0, 0, 0, 0));
        measure(per, high);
        @(posedge clk_out);
        #2;
        wr(0, cw(0, 1, 0, 0, 0, 1));
        #0.5;
        chk("R7 low right after kill", longint'(clk_out), 0);
        nr = n_rise;
        #2000;
        chk("R7 no edges while killed", longint'(n_rise - nr), 0);
        wr(0, cw(0, 1, 0, 0, 0, 0));
        measure(per, high);
        chk("R7 restart after kill period", per, 32000);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule